// File: doc/BRIEF.md
# Limb-Serial Montgomery Modular Multiplier

This block multiplies two residues that are already in Montgomery form and returns a·b·R⁻¹ mod n, with R = 2^391. It works on 17-bit limbs, so that every hardware multiply is 17×17 and no product overflows. The 381-bit operands are widened to 23 limbs (391 bits). A row of 23 limb multipliers forms one full-width-by-one-limb product per clock. Each of the three wide products takes 23 clocks:

- the full product t = a·b;
- the low half m = (t_lo·n') mod R;
- the reduction sum t + m·n, whose low 23 limbs are zero and are dropped. Dropping them is the division by R.

The low limbs of t are folded into the third product as it is formed. After that, one limb-serial adder/subtractor makes a fourth 23-clock pass. In that pass it forms u = t_hi + (t_lo + m·n)/R and u − n together, each limb with its own registered carry or borrow. The final choice keeps u − n whenever u ≥ n.

The caller presents a, b, the modulus n and the constant n' = −n⁻¹ mod R, then pulses `start`. The block samples these inputs only on that edge. A one-cycle `done` marks the new result, which then holds until the next result replaces it.

Top module: `mont_mul_serial`

## Requirements
- R1: For odd n < 2^381 and a, b < n, the result r satisfies r·2^391 ≡ a·b (mod n).
- R2: The result is always strictly less than n. A reduction sum equal to n yields zero, not n.
- R3: `done` is high for exactly one cycle, 93 clock edges (4·23+1) after the edge that samples `start` high in the idle state.
- R4: `result` changes only on the edge that raises `done`, and holds its value at all other times.
- R5: A `start` seen while an operation is in progress is ignored. The running result and its `done` timing are unchanged, and no extra `done` follows.
- R6: While reset is low, `done` is 0 and `result` is 0.
- R7: When either operand is zero, the result is zero.
- R8: When a = 2^391 mod n (the Montgomery form of one), the result equals b.
- R9: Changes on `op_a`, `op_b`, `modn` and `ninv` after the start edge have no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| op_a | input | 391 | Multiplicand a in Montgomery form, below n |
| op_b | input | 391 | Multiplier b in Montgomery form, below n |
| modn | input | 391 | Odd modulus n |
| ninv | input | 391 | Constant −n⁻¹ mod 2^391 |
| done | output | 1 | One-cycle pulse when `result` is new |
| result | output | 391 | a·b·2^−391 mod n, held between pulses |

## Verification
Each result is due 93 edges after its start edge: 23 edges for each of the three products, 23 for the add-and-subtract pass, and one to select and register the result. The bench raises `start` on a falling edge. It then samples `done` on the falling edge after each of the next 92 rising edges and expects it low on the first 92 and high after the 93rd. It reads `result` only at that point. One falling edge later it expects `done` low again. For hold and ignored-input checks, it observes `result` over a further span of idle cycles, or for a whole extra latency window, before it starts anything new.

// File: rtl/mm_pkg.sv
// Package: shared state encoding for the limb-serial Montgomery multiplier.
// Assumes nothing beyond a single clock domain.
package mm_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_PROD,   // t = a*b, limb by limb
        ST_LOWM,   // m = t_lo*n' mod R
        ST_RED,    // (t_lo + m*n) / R
        ST_FOLD,   // u = hi + t_hi and u - n, limb-serial
        ST_PICK    // select and register the result
    } mm_state_e;
endpackage

// File: rtl/mm_limb_row.sv
// Module: row of limb multipliers.
// Forms opnd * limb as one wide value, using one LIMB_W x LIMB_W multiply per
// operand limb. Combinational. Assumes opnd holds NLIMBS limbs.
module mm_limb_row #(
    parameter int LIMB_W = 17,
    parameter int NLIMBS = 23
) (
    input  logic [LIMB_W*NLIMBS-1:0]        opnd,
    input  logic [LIMB_W-1:0]               limb,
    output logic [LIMB_W*NLIMBS+LIMB_W-1:0] row
);
    localparam int TW = LIMB_W * NLIMBS;
    localparam int RW = TW + LIMB_W;
    localparam int PW = 2 * LIMB_W;

    logic [PW-1:0] pp [NLIMBS];

    // one limb product per operand limb
    for (genvar j = 0; j < NLIMBS; j++) begin : g_mul
        assign pp[j] = {{LIMB_W{1'b0}}, opnd[j*LIMB_W +: LIMB_W]} *
                       {{LIMB_W{1'b0}}, limb};
    end

    // sum the partial products at their limb offsets
    always_comb begin
        row = '0;
        for (int j = 0; j < NLIMBS; j++) begin
            row = row + (RW'(pp[j]) << (j * LIMB_W));
        end
    end
endmodule

// File: rtl/mm_addsub_limb.sv
// Module: shared limb adder/subtractor.
// Each enabled cycle it adds x + y + carry and subtracts n_l + borrow from
// that limb sum. Carry and borrow are registered between limbs, with limb 0
// first. clr restarts both chains.
module mm_addsub_limb #(
    parameter int LIMB_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [LIMB_W-1:0] x,
    input  logic [LIMB_W-1:0] y,
    input  logic [LIMB_W-1:0] n_l,
    output logic [LIMB_W-1:0] sum_l,
    output logic [LIMB_W-1:0] dif_l,
    output logic              carry,
    output logic              borrow
);
    logic [LIMB_W:0] s_w;
    logic [LIMB_W:0] d_w;

    // limb sum, then limb difference against the modulus limb
    always_comb begin
        s_w   = {1'b0, x} + {1'b0, y} + {{LIMB_W{1'b0}}, carry};
        sum_l = s_w[LIMB_W-1:0];
        d_w   = {1'b0, sum_l} - {1'b0, n_l} - {{LIMB_W{1'b0}}, borrow};
        dif_l = d_w[LIMB_W-1:0];
    end

    // carry and borrow registers between limbs
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            carry  <= 1'b0;
            borrow <= 1'b0;
        end else if (en) begin
            carry  <= s_w[LIMB_W];
            borrow <= d_w[LIMB_W];
        end
    end
endmodule

// File: rtl/mont_mul_serial.sv
// Module: limb-serial Montgomery multiplier, top level.
// Computes a*b*R^-1 mod n with R = 2^(LIMB_W*NLIMBS). It makes three passes of
// NLIMBS cycles over a row of limb multipliers, then one add-and-subtract pass,
// then a select cycle. Assumes odd n, a and b below n, and n below R/2.
module mont_mul_serial #(
    parameter int LIMB_W = 17,
    parameter int NLIMBS = 23
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [LIMB_W*NLIMBS-1:0] op_a,
    input  logic [LIMB_W*NLIMBS-1:0] op_b,
    input  logic [LIMB_W*NLIMBS-1:0] modn,
    input  logic [LIMB_W*NLIMBS-1:0] ninv,
    output logic                     done,
    output logic [LIMB_W*NLIMBS-1:0] result
);
    import mm_pkg::*;

    localparam int TW   = LIMB_W * NLIMBS;
    localparam int RW   = TW + LIMB_W;
    localparam int ACCW = RW + 1;
    localparam int CW   = (NLIMBS > 1) ? $clog2(NLIMBS) : 1;

    mm_state_e        st;
    logic [CW-1:0]    cnt;
    logic [TW-1:0]    aq, bq, nq, npq;
    logic [TW-1:0]    tlo, thi, mreg, ures, dres;
    logic [ACCW-1:0]  acc, s;
    logic [RW-1:0]    row;
    logic [TW-1:0]    opx;
    logic [LIMB_W-1:0] lmb, addend, sum_l, dif_l;
    logic             carry, borrow, last, accept;
    int unsigned      base;

    assign last   = (cnt == CW'(NLIMBS - 1));
    assign accept = (st == ST_IDLE) && start;

    // pick the wide operand and the scanned limb for this pass
    always_comb begin
        base   = 32'(cnt) * LIMB_W;
        opx    = '0;
        lmb    = '0;
        addend = '0;
        case (st)
            ST_PROD: begin opx = aq;  lmb = bq[base +: LIMB_W];   end
            ST_LOWM: begin opx = npq; lmb = tlo[base +: LIMB_W];  end
            ST_RED:  begin opx = nq;  lmb = mreg[base +: LIMB_W];
                           addend = tlo[base +: LIMB_W];          end
            default: ;
        endcase
    end

    mm_limb_row #(.LIMB_W(LIMB_W), .NLIMBS(NLIMBS)) u_row (
        .opnd (opx),
        .limb (lmb),
        .row  (row)
    );

    // running sum: accumulator + row product (+ t_lo limb while reducing)
    always_comb s = acc + {1'b0, row} + ACCW'(addend);

    mm_addsub_limb #(.LIMB_W(LIMB_W)) u_addsub (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (accept),
        .en     (st == ST_FOLD),
        .x      (acc[base +: LIMB_W]),
        .y      (thi[base +: LIMB_W]),
        .n_l    (nq[base +: LIMB_W]),
        .sum_l  (sum_l),
        .dif_l  (dif_l),
        .carry  (carry),
        .borrow (borrow)
    );

    // sequencing, limb storage and result register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            acc    <= '0;
            aq     <= '0; bq  <= '0; nq   <= '0; npq  <= '0;
            tlo    <= '0; thi <= '0; mreg <= '0;
            ures   <= '0; dres <= '0;
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: if (start) begin
                    aq  <= op_a; bq <= op_b; nq <= modn; npq <= ninv;
                    acc <= '0;
                    cnt <= '0;
                    st  <= ST_PROD;
                end
                ST_PROD: begin
                    tlo[base +: LIMB_W] <= s[LIMB_W-1:0];
                    if (last) begin
                        thi <= s[LIMB_W +: TW];
                        acc <= '0;
                        cnt <= '0;
                        st  <= ST_LOWM;
                    end else begin
                        acc <= s >> LIMB_W;
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_LOWM: begin
                    mreg[base +: LIMB_W] <= s[LIMB_W-1:0];
                    if (last) begin
                        acc <= '0;
                        cnt <= '0;
                        st  <= ST_RED;
                    end else begin
                        acc <= s >> LIMB_W;
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_RED: begin
                    acc <= s >> LIMB_W;
                    if (last) begin
                        cnt <= '0;
                        st  <= ST_FOLD;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_FOLD: begin
                    ures[base +: LIMB_W] <= sum_l;
                    dres[base +: LIMB_W] <= dif_l;
                    if (last) begin
                        cnt <= '0;
                        st  <= ST_PICK;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_PICK: begin
                    result <= (carry || !borrow) ? dres : ures;
                    done   <= 1'b1;
                    st     <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mm_chk.sv
// Module: property checker for mont_mul_serial, attached by bind.
// It keeps its own count of cycles since an accepted start and does not rely
// on the design's state register.
module mm_chk #(
    parameter int LIMB_W = 17,
    parameter int NLIMBS = 23
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     done,
    input logic [LIMB_W*NLIMBS-1:0] result,
    input logic [LIMB_W*NLIMBS-1:0] nq
);
    localparam int LAT = 4 * NLIMBS + 1;
    localparam int KW  = $clog2(LAT + 1);

    logic          c_busy;
    logic [KW-1:0] c_cnt;

    // independent model of when a start is taken and when done is due
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_busy <= 1'b0;
            c_cnt  <= '0;
        end else if (start && (!c_busy || c_cnt == KW'(LAT))) begin
            c_busy <= 1'b1;
            c_cnt  <= '0;
        end else if (c_busy) begin
            if (c_cnt == KW'(LAT)) c_busy <= 1'b0;
            else                   c_cnt  <= c_cnt + 1'b1;
        end
    end

    // R3
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (c_busy && c_cnt == KW'(LAT)));
    // R3 R5
    done_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_busy && c_cnt == KW'(LAT)) |-> done);
    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R4
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (done || $stable(result)));
    // R2
    result_below_n_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result < nq));
endmodule

bind mont_mul_serial mm_chk #(.LIMB_W(LIMB_W), .NLIMBS(NLIMBS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .done   (done),
    .result (result),
    .nq     (nq)
);

// File: tb/tb_mont_mul_serial.sv
`timescale 1ns/1ps
// Bench: table-driven and directed checks of mont_mul_serial against a
// big-integer relation r*2^391 mod n == a*b mod n.
module tb_mont_mul_serial;
    localparam int W   = 17;
    localparam int N   = 23;
    localparam int TW  = W * N;
    localparam int LAT = 4 * N + 1;
    localparam int BW  = 800;
    localparam int NV  = 6;

    localparam logic [TW-1:0] P381 = TW'(384'h1a0111ea397fe69a4b1ba7b6434bacd764774b84f38512bf6730d2a0f6b0f6241eabfffeb153ffffb9feffffffffaaab);

    localparam logic [TW-1:0] TA [NV] = '{
        TW'(1), TW'(2), TW'(128'hdeadbeef_01234567_89abcdef_fedcba98),
        TW'(256'h0f0e0d0c_0b0a0908_07060504_03020100_11223344_55667788_99aabbcc_ddeeff00),
        TW'(376'h00abcdef_12345678_9abcdef0_0fedcba9_87654321_00112233_44556677_8899aabb_ccddeeff_13579bdf_2468ace0_aa55aa55),
        TW'(64'hffffffff_ffffffff)};
    localparam logic [TW-1:0] TB [NV] = '{
        TW'(1), TW'(3), TW'(96'h00000001_00000000_00000001),
        TW'(200'h9f_8e7d6c5b_4a392817_06f5e4d3_c2b1a090_12345678_9abcdef0),
        TW'(376'h0055aa55_aa55aa55_0f0f0f0f_f0f0f0f0_12121212_34343434_56565656_78787878_9a9a9a9a_bcbcbcbc_dededede_f0f0f0f1),
        TW'(376'h00ffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff_ffffffff)};

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [TW-1:0] op_a, op_b, modn, ninv;
    logic          done;
    logic [TW-1:0] result;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    mont_mul_serial #(.LIMB_W(W), .NLIMBS(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .op_a(op_a), .op_b(op_b), .modn(modn), .ninv(ninv),
        .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [BW-1:0] act, input logic [BW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // -n^-1 mod 2^TW by Newton iteration
    function automatic logic [TW-1:0] ninv_of(input logic [TW-1:0] n);
        logic [TW-1:0] x = TW'(1);
        logic [TW-1:0] t;
        for (int i = 0; i < 10; i++) begin
            t = n * x;
            x = x * (TW'(2) - t);
        end
        return TW'(0) - x;
    endfunction

    function automatic logic [BW-1:0] lhs_of(input logic [TW-1:0] r, input logic [TW-1:0] n);
        return (BW'(r) << TW) % BW'(n);
    endfunction

    function automatic logic [BW-1:0] rhs_of(input logic [TW-1:0] a, input logic [TW-1:0] b,
                                             input logic [TW-1:0] n);
        return (BW'(a) * BW'(b)) % BW'(n);
    endfunction

    function automatic logic [TW-1:0] rnd_below(input logic [TW-1:0] n);
        logic [BW-1:0] v = '0;
        for (int i = 0; i < 13; i++) v = (v << 32) | BW'($urandom());
        return TW'(v % BW'(n));
    endfunction

    // one operation; noisy=1 keeps start high and scrambles inputs mid-run (R5, R9)
    task automatic run_op(input logic [TW-1:0] a, input logic [TW-1:0] b,
                          input logic [TW-1:0] n, input bit noisy,
                          output logic [TW-1:0] res);
        bit early = 1'b0;
        @(negedge clk);
        op_a = a; op_b = b; modn = n; ninv = ninv_of(n);
        start = 1'b1;
        @(negedge clk);
        start = noisy;
        if (noisy) begin op_a = ~a; op_b = b ^ TW'(5); modn = n + TW'(2); ninv = ~ninv; end
        for (int k = 0; k < LAT - 1; k++) begin
            @(negedge clk);
            if (done) early = 1'b1;
            if (k == LAT - 2) start = 1'b0;
        end
        chk(!early, "R3", "done before due cycle", BW'(early), BW'(0));
        @(negedge clk);
        chk(done === 1'b1, "R3", "done at due cycle", BW'(done), BW'(1));
        res = result;
        @(negedge clk);
        chk(done === 1'b0, "R3", "done one cycle wide", BW'(done), BW'(0));
    endtask

    task automatic check_rel(input logic [TW-1:0] a, input logic [TW-1:0] b,
                             input logic [TW-1:0] n, input logic [TW-1:0] r, input string req);
        chk(lhs_of(r, n) == rhs_of(a, b, n), req, "r*R mod n vs a*b mod n",
            lhs_of(r, n), rhs_of(a, b, n));
        chk(r < n, "R2", "result below n", BW'(r), BW'(n));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [TW-1:0] r, r2, a, b, n, one;
        rst_n = 1'b0; start = 1'b0;
        op_a = '0; op_b = '0; modn = '0; ninv = '0;
        repeat (3) @(negedge clk);
        // R6 reset state
        chk(done === 1'b0, "R6", "done in reset", BW'(done), BW'(0));
        chk(result === '0, "R6", "result in reset", BW'(result), BW'(0));
        @(negedge clk);
        rst_n = 1'b1;

        // vector table under the 381-bit modulus (R1)
        for (int i = 0; i < NV; i++) begin
            run_op(TA[i], TB[i], P381, 1'b0, r);
            check_rel(TA[i], TB[i], P381, r, "R1");
        end

        // random operands under three moduli (R1)
        for (int i = 0; i < 9; i++) begin
            n = (i < 3) ? P381 : (i < 6) ? ((TW'(1) << 381) - TW'(1)) : TW'(1000003);
            a = rnd_below(n);
            b = rnd_below(n);
            run_op(a, b, n, 1'b0, r);
            check_rel(a, b, n, r, "R1");
        end

        // extreme operands n-1 (R1, R2)
        run_op(P381 - TW'(1), P381 - TW'(1), P381, 1'b0, r);
        check_rel(P381 - TW'(1), P381 - TW'(1), P381, r, "R1");

        // R7 zero operand gives zero
        run_op('0, TA[4], P381, 1'b0, r);
        chk(r == '0, "R7", "a=0", BW'(r), BW'(0));
        run_op(TB[4], '0, P381, 1'b0, r);
        chk(r == '0, "R7", "b=0", BW'(r), BW'(0));

        // R8 Montgomery one times b gives b
        one = TW'((BW'(1) << TW) % BW'(P381));
        run_op(one, TB[4], P381, 1'b0, r);
        chk(r == TB[4], "R8", "one*b", BW'(r), BW'(TB[4]));
        one = TW'((BW'(1) << TW) % BW'(1000003));
        run_op(one, TW'(999999), TW'(1000003), 1'b0, r);
        chk(r == TW'(999999), "R8", "one*b small n", BW'(r), BW'(999999));

        // R5 R9 start held and inputs scrambled during the run
        run_op(TA[4], TB[4], P381, 1'b1, r);
        check_rel(TA[4], TB[4], P381, r, "R9");
        run_op(TA[4], TB[4], P381, 1'b0, r2);
        chk(r == r2, "R5", "noisy run equals clean run", BW'(r), BW'(r2));

        // R5 no extra done after a busy-time start; R4 result holds while idle
        op_a = ~op_a; op_b = '0; modn = TW'(7);
        begin
            bit extra = 1'b0;
            bit moved = 1'b0;
            for (int k = 0; k < LAT + 5; k++) begin
                @(negedge clk);
                if (done) extra = 1'b1;
                if (result !== r2) moved = 1'b1;
            end
            chk(!extra, "R5", "no extra done", BW'(extra), BW'(0));
            chk(!moved, "R4", "result held while idle", BW'(result), BW'(r2));
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule